// File: doc/BRIEF.md
# Multicycle Load/Store Processor Datapath

This block is the datapath of a 32-bit load/store processor that spreads each instruction over several clock cycles. A single ALU does every piece of arithmetic the machine needs: the PC increment, the branch target, the effective address and the register-register operation, each in a different cycle. A single memory port serves both instruction fetch and data access. Between steps, values are held in internal registers: program counter, instruction register, memory data register, two operand latches and an ALU result latch. The block also holds a 32-entry register file and a sign extender.

The block makes no sequencing decisions of its own. A separate controller drives every select and write enable on each cycle, and the block returns the opcode and function fields of the current instruction. The memory lives outside the block. It reads combinationally at `mem_addr` and writes on the rising clock edge while `mem_we` is high.

The instructions covered are register-register arithmetic, load word, store word, branch-if-equal and jump. Load and store use the immediate format: op[31:26], rs[25:21], rt[20:16], imm[15:0]. Register-register uses rd[15:11] and funct[5:0] in the same word. A jump takes its 26-bit target from bits 25:0.

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high on a rising edge, PC, IR, MDR, A, B and the ALU result latch clear to zero. In the first cycle after reset with all controls low, `mem_addr` = 0, `mem_wdata` = 0, `mem_we` = 0, and `opcode` and `funct` read 0.
- R2: Fetch cycle. With `addr_sel`=0, `mem_addr` equals PC, and `ir_wr` loads IR from `mem_rdata`. With `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_fn`=ADD, `pc_src`=0 (ALU output) and `pc_wr`=1, PC becomes PC+4. IR holds its value whenever `ir_wr` is low.
- R3: A and B latch register file entries IR[25:21] and IR[20:16] on every edge. With `alu_b_sel`=3, the ALU adds the sign-extended IR[15:0] shifted left by two, so a decode cycle leaves PC + (sext(imm)<<2) in the result latch, and that value may be negative.
- R4: `alu_fn` encodings are 010 add, 110 subtract, 000 AND, 001 OR and 111 signed set-less-than (result 1 or 0). Any other code yields 0. The zero flag is set when the ALU output is 0.
- R5: With `alu_a_sel`=1 (A) and `alu_b_sel`=2, the ALU forms A + sext(IR[15:0]). With `addr_sel`=1, `mem_addr` presents the result latch.
- R6: `mem_we` follows `mem_wr`, and `mem_wdata` always presents B. A store therefore writes Reg[rt] to the computed address.
- R7: MDR latches `mem_rdata` on every edge. With `reg_wr`=1, `wb_sel`=1 and `dst_sel`=0, the register selected by IR[20:16] receives MDR.
- R8: With `reg_wr`=1, `wb_sel`=0 and `dst_sel`=1, the register selected by IR[15:11] receives the result latch at the end of that cycle.
- R9: With `pc_wr_cond`=1, `pc_src`=1 and `alu_fn`=SUB on A and B, PC loads the result latch only when the ALU zero flag is set. Otherwise PC is unchanged.
- R10: With `pc_wr`=1 and `pc_src`=2, PC becomes {PC[31:28], IR[25:0], 2'b00}.
- R11: Register 0 always reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write when ALU zero flag set |
| pc_src | input | 2 | PC source: 0 ALU, 1 result latch, 2 jump target |
| addr_sel | input | 1 | Memory address: 0 PC, 1 result latch |
| mem_wr | input | 1 | Memory write request |
| ir_wr | input | 1 | Load IR from memory |
| reg_wr | input | 1 | Register file write |
| wb_sel | input | 1 | Write data: 0 result latch, 1 MDR |
| dst_sel | input | 1 | Write register: 0 IR[20:16], 1 IR[15:11] |
| alu_a_sel | input | 1 | ALU A: 0 PC, 1 A latch |
| alu_b_sel | input | 2 | ALU B: 0 B latch, 1 four, 2 sext imm, 3 sext imm<<2 |
| alu_fn | input | 3 | ALU function code |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (B latch) |
| mem_we | output | 1 | Memory write enable |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |

## Verification
Most internal faults show up at the memory port within one instruction. A wrong PC increment, branch decision, branch target or jump target puts a wrong address on the next fetch cycle. A wrong A, B, ALU function or register write shows as a wrong store address or store data once a later store reads that register. Register values are therefore checked indirectly, by storing them, and each error is caught within the few cycles between the faulty step and the next fetch or store. A register-0 write that is not discarded shows as nonzero data on the store of register 0 that follows.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam logic [2:0] FN_AND = 3'b000;
  localparam logic [2:0] FN_OR  = 3'b001;
  localparam logic [2:0] FN_ADD = 3'b010;
  localparam logic [2:0] FN_SUB = 3'b110;
  localparam logic [2:0] FN_SLT = 3'b111;

  localparam logic [1:0] SRCB_REG  = 2'd0;
  localparam logic [1:0] SRCB_FOUR = 2'd1;
  localparam logic [1:0] SRCB_IMM  = 2'd2;
  localparam logic [1:0] SRCB_IMMW = 2'd3;

  localparam logic [1:0] PCS_ALU  = 2'd0;
  localparam logic [1:0] PCS_LAT  = 2'd1;
  localparam logic [1:0] PCS_JUMP = 2'd2;
endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn,
  output logic [W-1:0] y,
  output logic         zero
);
  import mc_pkg::*;

  always_comb begin
    case (fn)
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we && wa != '0) store[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : store[ra1];
  assign rd2 = (ra2 == '0) ? '0 : store[ra2];

  // R11
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0 && ra1 == '0) |=> (ra1 != '0 || rd1 == '0));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_wr,
  input  logic              pc_wr_cond,
  input  logic [1:0]        pc_src,
  input  logic              addr_sel,
  input  logic              mem_wr,
  input  logic              ir_wr,
  input  logic              reg_wr,
  input  logic              wb_sel,
  input  logic              dst_sel,
  input  logic              alu_a_sel,
  input  logic [1:0]        alu_b_sel,
  input  logic [2:0]        alu_fn,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [5:0]        opcode,
  output logic [5:0]        funct
);
  import mc_pkg::*;

  localparam int IMM_W   = 16;
  localparam int JMP_W   = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int OP_LSB  = 26;
  localparam int PC_HI_W = DATA_W - JMP_W - 2;

  logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, lat_q;
  logic [DATA_W-1:0] sext, sext_w, alu_a, alu_b, alu_y, pc_next, rf_wd;
  logic [DATA_W-1:0] rf_rd1, rf_rd2;
  logic [REG_AW-1:0] rf_wa;
  logic              alu_zero, pc_en;

  assign sext   = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign sext_w = {sext[DATA_W-3:0], 2'b00};

  assign alu_a = alu_a_sel ? a_q : pc_q;
  always_comb begin
    case (alu_b_sel)
      SRCB_REG:  alu_b = b_q;
      SRCB_FOUR: alu_b = DATA_W'(4);
      SRCB_IMM:  alu_b = sext;
      default:   alu_b = sext_w;
    endcase
  end

  mc_alu #(.W(DATA_W)) u_alu (
    .a(alu_a), .b(alu_b), .fn(alu_fn), .y(alu_y), .zero(alu_zero)
  );

  assign rf_wa = dst_sel ? ir_q[RD_LSB +: REG_AW] : ir_q[RT_LSB +: REG_AW];
  assign rf_wd = wb_sel ? mdr_q : lat_q;

  mc_regfile #(.W(DATA_W), .AW(REG_AW)) u_rf (
    .clk(clk), .rst(rst), .we(reg_wr), .wa(rf_wa), .wd(rf_wd),
    .ra1(ir_q[RS_LSB +: REG_AW]), .ra2(ir_q[RT_LSB +: REG_AW]),
    .rd1(rf_rd1), .rd2(rf_rd2)
  );

  always_comb begin
    case (pc_src)
      PCS_ALU:  pc_next = alu_y;
      PCS_LAT:  pc_next = lat_q;
      PCS_JUMP: pc_next = {pc_q[DATA_W-1 -: PC_HI_W], ir_q[JMP_W-1:0], 2'b00};
      default:  pc_next = pc_q;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      lat_q <= '0;
    end else begin
      if (pc_en) pc_q <= pc_next;
      if (ir_wr) ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rf_rd1;
      b_q   <= rf_rd2;
      lat_q <= alu_y;
    end
  end

  assign mem_addr  = addr_sel ? lat_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = mem_wr;
  assign opcode    = ir_q[OP_LSB +: 6];
  assign funct     = ir_q[5:0];

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable(ir_q));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_src == PCS_ALU && !alu_a_sel && alu_b_sel == SRCB_FOUR && alu_fn == FN_ADD)
    |=> pc_q == $past(pc_q) + DATA_W'(4));

  // R9
  br_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_cond && !pc_wr && alu_fn == FN_SUB && alu_a_sel && alu_b_sel == SRCB_REG && a_q != b_q)
    |=> $stable(pc_q));

  // R9
  br_take_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_cond && pc_src == PCS_LAT && alu_fn == FN_SUB && alu_a_sel && alu_b_sel == SRCB_REG && a_q == b_q)
    |=> pc_q == $past(lat_q));

  // R10
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_src == PCS_JUMP)
    |=> pc_q[DATA_W-PC_HI_W-1:0] == {$past(ir_q[JMP_W-1:0]), 2'b00});
endmodule

// File: tb/mc_datapath_test.sv
`timescale 1ns/1ps
module mc_datapath_test;
  import mc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, reg_wr, wb_sel, dst_sel, alu_a_sel;
  logic [1:0]  pc_src, alu_b_sel;
  logic [2:0]  alu_fn;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we;
  logic [5:0]  opcode, funct;

  always #2.5 clk = ~clk;

  mc_datapath uut (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .addr_sel(addr_sel), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
    .wb_sel(wb_sel), .dst_sel(dst_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .alu_fn(alu_fn), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .opcode(opcode), .funct(funct)
  );

  logic [31:0] bmem [1024];
  assign mem_rdata = bmem[mem_addr[11:2]];
  always @(posedge clk) if (mem_we) bmem[mem_addr[11:2]] <= mem_wdata;

  typedef struct {
    logic        st;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } item_t;
  item_t exp_q[$];

  int checks = 0, fails = 0;
  logic fetch_flag = 1'b0;
  logic [31:0] pc_exp = 0;
  logic [31:0] rf [32];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected memory events at the falling edge
  always @(negedge clk) begin
    if (!rst && (fetch_flag || mem_we)) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 unexpected access actual=%h expected=none", mem_addr);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk({it.req, " kind"}, {31'd0, mem_we}, {31'd0, it.st});
        chk({it.req, " addr"}, mem_addr, it.addr);
        if (it.st) chk({it.req, " data"}, mem_wdata, it.data);
      end
    end
  end

  function automatic logic [31:0] alu_model(logic [2:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      FN_AND:  return a & b;
      FN_OR:   return a | b;
      FN_ADD:  return a + b;
      FN_SUB:  return a - b;
      FN_SLT:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; pc_src = 0; addr_sel = 0; mem_wr = 0; ir_wr = 0;
    reg_wr = 0; wb_sel = 0; dst_sel = 0; alu_a_sel = 0; alu_b_sel = 0; alu_fn = FN_ADD;
  endtask

  task automatic go();
    @(posedge clk); #1;
  endtask

  task automatic fetch(logic [31:0] word);
    item_t it;
    bmem[pc_exp[11:2]] = word;
    it.st = 0; it.addr = pc_exp; it.data = 0; it.req = "R2 fetch";
    exp_q.push_back(it);
    idle(); ir_wr = 1; alu_b_sel = SRCB_FOUR; pc_wr = 1; fetch_flag = 1;
    go();
    fetch_flag = 0;
    pc_exp = pc_exp + 4;
  endtask

  task automatic decode(logic [31:0] word);
    idle(); alu_b_sel = SRCB_IMMW;
    @(negedge clk);
    chk("R2 opcode", {26'd0, opcode}, {26'd0, word[31:26]});
    chk("R2 funct", {26'd0, funct}, {26'd0, word[5:0]});
    @(posedge clk); #1;
  endtask

  task automatic run_r(int rd, int rs, int rt, logic [2:0] fn, logic [5:0] fc);
    logic [31:0] w;
    w = {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fc};
    fetch(w); decode(w);
    idle(); alu_a_sel = 1; alu_b_sel = SRCB_REG; alu_fn = fn; go();
    idle(); reg_wr = 1; dst_sel = 1; go();
    if (rd != 0) rf[rd] = alu_model(fn, rf[rs], rf[rt]);
  endtask

  task automatic run_lw(int rt, int rs, logic [15:0] imm);
    logic [31:0] w, ea;
    w = {6'h23, 5'(rs), 5'(rt), imm};
    ea = rf[rs] + sx(imm);
    fetch(w); decode(w);
    idle(); alu_a_sel = 1; alu_b_sel = SRCB_IMM; go();
    idle(); addr_sel = 1; go();
    idle(); reg_wr = 1; wb_sel = 1; go();
    if (rt != 0) rf[rt] = bmem[ea[11:2]];
  endtask

  task automatic run_sw(int rt, int rs, logic [15:0] imm, string req);
    logic [31:0] w;
    item_t it;
    w = {6'h2b, 5'(rs), 5'(rt), imm};
    fetch(w); decode(w);
    idle(); alu_a_sel = 1; alu_b_sel = SRCB_IMM; go();
    it.st = 1; it.addr = rf[rs] + sx(imm); it.data = rf[rt]; it.req = req;
    exp_q.push_back(it);
    idle(); addr_sel = 1; mem_wr = 1; go();
  endtask

  task automatic run_beq(int rs, int rt, logic [15:0] imm);
    logic [31:0] w;
    w = {6'h04, 5'(rs), 5'(rt), imm};
    fetch(w); decode(w);
    idle(); alu_a_sel = 1; alu_b_sel = SRCB_REG; alu_fn = FN_SUB;
    pc_wr_cond = 1; pc_src = PCS_LAT; go();
    if (rf[rs] == rf[rt]) pc_exp = pc_exp + {sx(imm)[29:0], 2'b00};
  endtask

  task automatic run_j(logic [25:0] tgt);
    logic [31:0] w;
    w = {6'h02, tgt};
    fetch(w); decode(w);
    idle(); pc_wr = 1; pc_src = PCS_JUMP; go();
    pc_exp = {pc_exp[31:28], tgt, 2'b00};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 32'd0;
    for (int i = 0; i < 32; i++) rf[i] = 32'd0;
    bmem[32'h400 >> 2] = 32'h1111_1111;
    bmem[32'h404 >> 2] = 32'h8000_0002;
    idle();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem_addr", mem_addr, 32'd0);
    chk("R1 mem_wdata", mem_wdata, 32'd0);
    chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
    chk("R1 opcode", {26'd0, opcode}, 32'd0);
    @(posedge clk); #1;

    run_lw(2, 0, 16'h0400);              // R7 R5
    run_lw(3, 0, 16'h0404);              // R7
    run_r(4, 2, 3, FN_ADD, 6'h20);       // R8 R4 add
    run_sw(4, 0, 16'h0408, "R8 add");
    run_r(5, 3, 2, FN_SUB, 6'h22);
    run_sw(5, 0, 16'h040C, "R4 sub");
    run_r(6, 2, 3, FN_AND, 6'h24);
    run_sw(6, 0, 16'h0410, "R4 and");
    run_r(7, 2, 3, FN_OR, 6'h25);
    run_sw(7, 0, 16'h0414, "R4 or");
    run_r(8, 2, 3, FN_SLT, 6'h2a);
    run_sw(8, 0, 16'h0418, "R4 slt");
    run_r(9, 3, 2, FN_SLT, 6'h2a);
    run_sw(9, 0, 16'h041C, "R4 slt neg");
    run_sw(2, 0, 16'h0420, "R7 load");
    run_r(0, 2, 3, FN_ADD, 6'h20);       // R11 write discarded
    run_sw(0, 0, 16'h0424, "R11 zero");
    run_beq(2, 3, 16'h0005);             // R9 not taken
    run_beq(4, 7, 16'h0002);             // R9 taken, R3 target
    run_j(26'h00000C0);                  // R10 to 0x300
    run_beq(0, 0, 16'hFFFD);             // R3 negative offset
    run_sw(9, 0, 16'h0428, "R10 R3 path");
    run_lw(10, 0, 16'h0408);             // R6 stored data readback
    run_sw(10, 0, 16'h042C, "R6 readback");
    idle();
    repeat (2) @(posedge clk);
    chk("R6 queue drained", exp_q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule